// File: doc/BRIEF.md
# Dual-Pointer Modulo Address Generator

This block supplies the two operand addresses a multiply-accumulate datapath needs in every cycle: one into X data space and one into Y data space. Each address comes from a pointer register chosen by the current control word. The chosen pointers are then updated at the clock edge. The update adds one, subtracts one or adds a programmed signed step. It can also wrap inside a circular buffer, with one buffer for the X side and one for the Y side.

The X address port has three more sources. A software stack uses a stack pointer that drops by one before a push and rises by one after a pop. A base register serves indexed accesses, where a signed 8-bit offset is added to the base. The pointer can also be read directly. A single write port and a single read port give access to every register. The instruction decoder drives the control fields in the same cycle as the access. Both addresses are combinational from the current register state.

Top module: `dual_mod_agu`

## Requirements
- R1: After reset, every register reads 0 and both addresses are 0.
- R2: With X source 0 (pointer), xAddr equals the pointer chosen by xSel in that same cycle, before its update. yAddr always equals the pointer chosen by ySel.
- R3: At the clock edge a pointer is updated according to its op code: 0 hold, 1 add one, 2 subtract one, 3 add the STEP register as a signed 16-bit value. An X update happens only when the X source is 0.
- R4: When circular mode is set, the buffer runs from START to START+LEN-1 (registers 7/8 for X, 9/10 for Y). A result above the end is reduced by LEN, and a result below START is raised by LEN. So stepping one past the end gives START, and stepping one below START gives the end.
- R5: X source 1 (push) outputs SP-1 on xAddr, and SP becomes SP-1 at the edge.
- R6: X source 2 (pop) outputs SP on xAddr, and SP becomes SP+1 at the edge.
- R7: X source 3 (indexed) outputs BASE plus the sign-extended 8-bit idxOff. No pointer changes in that cycle.
- R8: A register write in the same cycle as a post-modify or a stack update of that register wins. The written value is kept.
- R9: When X updates pointer k and ySel also selects k with a non-hold op, only the X update is applied. When X does not update k, the Y update is applied.
- R10: rdData shows register rdReg (0-3 pointers, 4 SP, 5 BASE, 6 STEP, 7-10 buffer bounds) combinationally. A write becomes visible after the clock edge. Indices 11-15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xSel | input | 2 | Pointer used for the X side |
| xOp | input | 2 | X post-modify op code |
| xCirc | input | 1 | X circular mode |
| xSrc | input | 2 | X address source: pointer, push, pop, indexed |
| idxOff | input | 8 | Signed offset for indexed access |
| ySel | input | 2 | Pointer used for the Y side |
| yOp | input | 2 | Y post-modify op code |
| yCirc | input | 1 | Y circular mode |
| wrEn | input | 1 | Register write strobe |
| wrReg | input | 4 | Register write index |
| wrData | input | 16 | Register write data |
| rdReg | input | 4 | Register read index |
| rdData | output | 16 | Register read data |
| xAddr | output | 16 | X data address |
| yAddr | output | 16 | Y data address |

## Verification
The contested events are a register write and an update of the same register at the same edge. The update can be a pointer post-modify or a stack push or pop. The bench writes a pointer while X increments it, and writes SP during a push. It then reads the register back through rdData in the next cycle and expects the written value. The same read-back method covers the case where X and Y both select one pointer, where only the X update may land.

// File: rtl/agu_pkg.sv
package agu_pkg;
  parameter int AW     = 16;
  parameter int PTR_N  = 4;
  parameter int IDX_W  = 8;
  localparam int SEL_W = $clog2(PTR_N);
  localparam int RA_W  = 4;

  localparam logic [RA_W-1:0] REG_SP     = RA_W'(PTR_N);
  localparam logic [RA_W-1:0] REG_BASE   = RA_W'(PTR_N + 1);
  localparam logic [RA_W-1:0] REG_STEP   = RA_W'(PTR_N + 2);
  localparam logic [RA_W-1:0] REG_XSTART = RA_W'(PTR_N + 3);
  localparam logic [RA_W-1:0] REG_XLEN   = RA_W'(PTR_N + 4);
  localparam logic [RA_W-1:0] REG_YSTART = RA_W'(PTR_N + 5);
  localparam logic [RA_W-1:0] REG_YLEN   = RA_W'(PTR_N + 6);

  typedef enum logic [1:0] {OP_HOLD, OP_INC, OP_DEC, OP_STEP} mod_op_e;
  typedef enum logic [1:0] {SRC_PTR, SRC_PUSH, SRC_POP, SRC_INDEX} x_src_e;

  typedef struct packed {
    logic             wr;
    logic [RA_W-1:0]  wrIdx;
    logic             xUpd;
    logic [SEL_W-1:0] xIdx;
    mod_op_e          xOp;
    logic             xCirc;
    x_src_e           xSrc;
    logic             yUpd;
    logic [SEL_W-1:0] yIdx;
    mod_op_e          yOp;
    logic             yCirc;
    logic             spDec;
    logic             spInc;
  } agu_strb_t;

  function automatic logic [AW-1:0] postMod(
    input logic [AW-1:0] p,
    input mod_op_e       op,
    input logic [AW-1:0] step,
    input logic          circ,
    input logic [AW-1:0] start,
    input logic [AW-1:0] len
  );
    logic signed [AW+1:0] d, sum, lo, hi, l;
    case (op)
      OP_INC:  d = {{(AW+1){1'b0}}, 1'b1};
      OP_DEC:  d = '1;
      OP_STEP: d = {{2{step[AW-1]}}, step};
      default: d = '0;
    endcase
    sum = signed'({2'b00, p}) + d;
    lo  = signed'({2'b00, start});
    l   = signed'({2'b00, len});
    hi  = lo + l - {{(AW+1){1'b0}}, 1'b1};
    if (circ) begin
      if (d > 0 && sum > hi)      sum = sum - l;
      else if (d < 0 && sum < lo) sum = sum + l;
    end
    return sum[AW-1:0];
  endfunction
endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic [SEL_W-1:0] xSel,
  input  logic [1:0]       xOp,
  input  logic             xCirc,
  input  logic [1:0]       xSrc,
  input  logic [SEL_W-1:0] ySel,
  input  logic [1:0]       yOp,
  input  logic             yCirc,
  input  logic             wrEn,
  input  logic [RA_W-1:0]  wrReg,
  output agu_strb_t        strb
);
  logic xMods, yMods, xHit, yHit, spHit;

  always_comb begin
    xMods = (x_src_e'(xSrc) == SRC_PTR) && (mod_op_e'(xOp) != OP_HOLD);
    yMods = mod_op_e'(yOp) != OP_HOLD;
    xHit  = wrEn && (wrReg == RA_W'(xSel));
    yHit  = wrEn && (wrReg == RA_W'(ySel));
    spHit = wrEn && (wrReg == REG_SP);

    strb.wr    = wrEn;
    strb.wrIdx = wrReg;
    strb.xIdx  = xSel;
    strb.xOp   = mod_op_e'(xOp);
    strb.xCirc = xCirc;
    strb.xSrc  = x_src_e'(xSrc);
    strb.yIdx  = ySel;
    strb.yOp   = mod_op_e'(yOp);
    strb.yCirc = yCirc;
    // write beats post-modify; X beats Y on a shared pointer
    strb.xUpd  = xMods && !xHit;
    strb.yUpd  = yMods && !yHit && !(xMods && (xSel == ySel));
    strb.spDec = (x_src_e'(xSrc) == SRC_PUSH) && !spHit;
    strb.spInc = (x_src_e'(xSrc) == SRC_POP) && !spHit;
  end
endmodule

// File: rtl/agu_dp.sv
module agu_dp
  import agu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  agu_strb_t        strb,
  input  logic [IDX_W-1:0] idxOff,
  input  logic [AW-1:0]    wrData,
  input  logic [RA_W-1:0]  rdReg,
  output logic [AW-1:0]    rdData,
  output logic [AW-1:0]    xAddr,
  output logic [AW-1:0]    yAddr
);
  logic [AW-1:0] ptrQ [PTR_N];
  logic [AW-1:0] spQ, baseQ, stepQ, xStartQ, xLenQ, yStartQ, yLenQ;
  logic [AW-1:0] xPtr, yPtr, xNext, yNext;

  assign xPtr  = ptrQ[strb.xIdx];
  assign yPtr  = ptrQ[strb.yIdx];
  assign xNext = postMod(xPtr, strb.xOp, stepQ, strb.xCirc, xStartQ, xLenQ);
  assign yNext = postMod(yPtr, strb.yOp, stepQ, strb.yCirc, yStartQ, yLenQ);

  for (genvar i = 0; i < PTR_N; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rstN)                                      ptrQ[i] <= '0;
      else if (strb.wr && strb.wrIdx == RA_W'(i))     ptrQ[i] <= wrData;
      else if (strb.xUpd && strb.xIdx == SEL_W'(i))   ptrQ[i] <= xNext;
      else if (strb.yUpd && strb.yIdx == SEL_W'(i))   ptrQ[i] <= yNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                  spQ <= '0;
    else if (strb.wr && strb.wrIdx == REG_SP)   spQ <= wrData;
    else if (strb.spDec)                        spQ <= spQ - 1'b1;
    else if (strb.spInc)                        spQ <= spQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0; stepQ <= '0;
      xStartQ <= '0; xLenQ <= '0; yStartQ <= '0; yLenQ <= '0;
    end else if (strb.wr) begin
      case (strb.wrIdx)
        REG_BASE:   baseQ   <= wrData;
        REG_STEP:   stepQ   <= wrData;
        REG_XSTART: xStartQ <= wrData;
        REG_XLEN:   xLenQ   <= wrData;
        REG_YSTART: yStartQ <= wrData;
        REG_YLEN:   yLenQ   <= wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (strb.xSrc)
      SRC_PUSH:  xAddr = spQ - 1'b1;
      SRC_POP:   xAddr = spQ;
      SRC_INDEX: xAddr = baseQ + {{(AW-IDX_W){idxOff[IDX_W-1]}}, idxOff};
      default:   xAddr = xPtr;
    endcase
    yAddr = yPtr;
  end

  always_comb begin
    rdData = '0;
    if (rdReg < RA_W'(PTR_N)) rdData = ptrQ[rdReg[SEL_W-1:0]];
    else begin
      case (rdReg)
        REG_SP:     rdData = spQ;
        REG_BASE:   rdData = baseQ;
        REG_STEP:   rdData = stepQ;
        REG_XSTART: rdData = xStartQ;
        REG_XLEN:   rdData = xLenQ;
        REG_YSTART: rdData = yStartQ;
        REG_YLEN:   rdData = yLenQ;
        default:    rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/dual_mod_agu.sv
module dual_mod_agu
  import agu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] xSel,
  input  logic [1:0]       xOp,
  input  logic             xCirc,
  input  logic [1:0]       xSrc,
  input  logic [IDX_W-1:0] idxOff,
  input  logic [SEL_W-1:0] ySel,
  input  logic [1:0]       yOp,
  input  logic             yCirc,
  input  logic             wrEn,
  input  logic [RA_W-1:0]  wrReg,
  input  logic [AW-1:0]    wrData,
  input  logic [RA_W-1:0]  rdReg,
  output logic [AW-1:0]    rdData,
  output logic [AW-1:0]    xAddr,
  output logic [AW-1:0]    yAddr
);
  agu_strb_t strb;

  agu_ctrl u_ctrl (
    .xSel(xSel), .xOp(xOp), .xCirc(xCirc), .xSrc(xSrc),
    .ySel(ySel), .yOp(yOp), .yCirc(yCirc),
    .wrEn(wrEn), .wrReg(wrReg), .strb(strb)
  );

  agu_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .idxOff(idxOff),
    .wrData(wrData), .rdReg(rdReg), .rdData(rdData),
    .xAddr(xAddr), .yAddr(yAddr)
  );
endmodule

// File: rtl/agu_checker.sv
module agu_checker
  import agu_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [SEL_W-1:0] xSel,
  input logic [1:0]       xOp,
  input logic             xCirc,
  input logic [1:0]       xSrc,
  input logic [IDX_W-1:0] idxOff,
  input logic [SEL_W-1:0] ySel,
  input logic             wrEn,
  input logic [RA_W-1:0]  wrReg,
  input logic [AW-1:0]    wrData,
  input logic [RA_W-1:0]  rdReg,
  input logic [AW-1:0]    rdData,
  input logic [AW-1:0]    xAddr,
  input logic [AW-1:0]    yAddr
);
  AST_X_FROM_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (xSrc == 2'd0 && rdReg == RA_W'(xSel)) |-> xAddr == rdData);   // R2
  AST_Y_FROM_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (rdReg == RA_W'(ySel)) |-> yAddr == rdData);                   // R2
  AST_X_INC_LINEAR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(xSrc == 2'd0 && xOp == 2'd1 && !xCirc
       && !(wrEn && wrReg == RA_W'(xSel)))
     && xSrc == 2'd0 && xSel == $past(xSel))
    |-> xAddr == $past(xAddr) + 16'd1);                           // R3
  AST_PUSH_POP_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(xSrc == 2'd1 && !(wrEn && wrReg == REG_SP))
     && xSrc == 2'd2) |-> xAddr == $past(xAddr));                  // R5
  AST_POP_RUN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(xSrc == 2'd2 && !(wrEn && wrReg == REG_SP))
     && xSrc == 2'd2) |-> xAddr == $past(xAddr) + 16'd1);          // R6
  AST_INDEX_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (xSrc == 2'd3 && rdReg == REG_BASE)
    |-> xAddr == rdData + {{(AW-IDX_W){idxOff[IDX_W-1]}}, idxOff}); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrEn) && $past(wrReg) <= REG_YLEN
     && rdReg == $past(wrReg)) |-> rdData == $past(wrData));       // R8
endmodule

bind dual_mod_agu agu_checker u_chk (
  .clk(clk), .rstN(rstN), .xSel(xSel), .xOp(xOp), .xCirc(xCirc),
  .xSrc(xSrc), .idxOff(idxOff), .ySel(ySel), .wrEn(wrEn),
  .wrReg(wrReg), .wrData(wrData), .rdReg(rdReg), .rdData(rdData),
  .xAddr(xAddr), .yAddr(yAddr)
);

// File: tb/tb_dual_mod_agu.sv
module tb_dual_mod_agu;
  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] xSel = '0, xOp = '0, xSrc = '0, ySel = '0, yOp = '0;
  logic xCirc = 1'b0, yCirc = 1'b0, wrEn = 1'b0;
  logic [7:0] idxOff = '0;
  logic [3:0] wrReg = '0, rdReg = '0;
  logic [15:0] wrData = '0, rdData, xAddr, yAddr;
  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_mod_agu dut (.*);

  typedef struct packed {
    logic wr; logic [3:0] wReg; logic [15:0] wDat;
    logic [1:0] xs; logic [1:0] xo; logic xc;
    logic [1:0] ys; logic [1:0] yo; logic yc;
    logic [3:0] rr; logic [15:0] eX; logic [15:0] eY; logic [15:0] eR;
  } vec_t;

  // R3 linear steps, R4 wraps (X buffer 0x100..0x103, Y buffer 0x1FE..0x200)
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd0,  16'h0100, 2'd0, 2'd0, 1'b0, 2'd1, 2'd0, 1'b0, 4'd0,  16'h0000, 16'h0000, 16'h0000},
    '{1'b1, 4'd1,  16'h0200, 2'd0, 2'd0, 1'b0, 2'd1, 2'd0, 1'b0, 4'd0,  16'h0100, 16'h0000, 16'h0100},
    '{1'b1, 4'd7,  16'h0100, 2'd0, 2'd0, 1'b0, 2'd1, 2'd0, 1'b0, 4'd1,  16'h0100, 16'h0200, 16'h0200},
    '{1'b1, 4'd8,  16'h0004, 2'd0, 2'd1, 1'b1, 2'd1, 2'd2, 1'b0, 4'd7,  16'h0100, 16'h0200, 16'h0100},
    '{1'b1, 4'd9,  16'h01FE, 2'd0, 2'd1, 1'b1, 2'd1, 2'd1, 1'b0, 4'd8,  16'h0101, 16'h01FF, 16'h0004},
    '{1'b1, 4'd10, 16'h0003, 2'd0, 2'd0, 1'b0, 2'd1, 2'd0, 1'b0, 4'd9,  16'h0102, 16'h0200, 16'h01FE},
    '{1'b0, 4'd0,  16'h0000, 2'd0, 2'd1, 1'b1, 2'd1, 2'd1, 1'b1, 4'd10, 16'h0102, 16'h0200, 16'h0003},
    '{1'b1, 4'd6,  16'h0003, 2'd0, 2'd1, 1'b1, 2'd1, 2'd2, 1'b1, 4'd0,  16'h0103, 16'h01FE, 16'h0103},
    '{1'b0, 4'd0,  16'h0000, 2'd0, 2'd2, 1'b1, 2'd1, 2'd0, 1'b0, 4'd6,  16'h0100, 16'h0200, 16'h0003},
    '{1'b0, 4'd0,  16'h0000, 2'd0, 2'd3, 1'b1, 2'd1, 2'd3, 1'b0, 4'd0,  16'h0103, 16'h0200, 16'h0103},
    '{1'b1, 4'd6,  16'hFFFE, 2'd0, 2'd0, 1'b0, 2'd1, 2'd0, 1'b0, 4'd0,  16'h0102, 16'h0203, 16'h0102},
    '{1'b0, 4'd0,  16'h0000, 2'd0, 2'd3, 1'b1, 2'd1, 2'd3, 1'b0, 4'd1,  16'h0102, 16'h0203, 16'h0203},
    '{1'b0, 4'd0,  16'h0000, 2'd0, 2'd3, 1'b1, 2'd1, 2'd0, 1'b0, 4'd0,  16'h0100, 16'h0201, 16'h0100},
    '{1'b0, 4'd0,  16'h0000, 2'd0, 2'd0, 1'b0, 2'd1, 2'd0, 1'b0, 4'd0,  16'h0102, 16'h0201, 16'h0102}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [3:0] wr, input logic [15:0] wd,
                       input logic [1:0] src, input logic [7:0] idx,
                       input logic [1:0] xs, input logic [1:0] xo, input logic xc,
                       input logic [1:0] ys, input logic [1:0] yo, input logic yc,
                       input logic [3:0] rr);
    @(negedge clk);
    wrEn = w; wrReg = wr; wrData = wd; xSrc = src; idxOff = idx;
    xSel = xs; xOp = xo; xCirc = xc; ySel = ys; yOp = yo; yCirc = yc; rdReg = rr;
    #1;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state through the read port and both addresses
    for (int r = 0; r <= 10; r++) begin
      drive(0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 4'(r));
      chk("R1 reg", rdData, 16'h0);
    end
    chk("R1 xAddr", xAddr, 16'h0);
    chk("R1 yAddr", yAddr, 16'h0);

    // R2 R3 R4 R10 table walk
    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].wr, VECS[v].wReg, VECS[v].wDat, 2'd0, 0,
            VECS[v].xs, VECS[v].xo, VECS[v].xc, VECS[v].ys, VECS[v].yo, VECS[v].yc, VECS[v].rr);
      chk("R2/R3/R4 xAddr", xAddr, VECS[v].eX);
      chk("R2/R3/R4 yAddr", yAddr, VECS[v].eY);
      chk("R10 rdData", rdData, VECS[v].eR);
    end

    // R5 push from SP=0, then R6 pop
    drive(0, 0, 0, 2'd1, 0, 0, 0, 0, 1, 0, 0, 4'd4);
    chk("R5 push addr", xAddr, 16'hFFFF);
    drive(0, 0, 0, 2'd2, 0, 0, 0, 0, 1, 0, 0, 4'd4);
    chk("R5 SP after push", rdData, 16'hFFFF);
    chk("R6 pop addr", xAddr, 16'hFFFF);
    drive(0, 0, 0, 2'd0, 0, 0, 0, 0, 1, 0, 0, 4'd4);
    chk("R6 SP after pop", rdData, 16'h0000);

    // R7 indexed, with an X op that must have no effect
    drive(1, 4'd5, 16'h1000, 2'd0, 0, 0, 0, 0, 1, 0, 0, 4'd0);
    drive(0, 0, 0, 2'd3, 8'hF0, 0, 2'd1, 0, 1, 0, 0, 4'd0);
    chk("R7 negative offset", xAddr, 16'h0FF0);
    drive(0, 0, 0, 2'd3, 8'h7F, 0, 2'd1, 0, 1, 0, 0, 4'd0);
    chk("R7 positive offset", xAddr, 16'h107F);
    chk("R7 pointer untouched", rdData, 16'h0102);

    // R8 write beats post-modify and stack update
    drive(1, 4'd2, 16'h0500, 2'd0, 0, 2'd2, 2'd1, 0, 1, 0, 0, 4'd2);
    drive(1, 4'd4, 16'h0040, 2'd1, 0, 2'd2, 0, 0, 1, 0, 0, 4'd2);
    chk("R8 pointer write wins", rdData, 16'h0500);
    drive(0, 0, 0, 2'd0, 0, 0, 0, 0, 1, 0, 0, 4'd4);
    chk("R8 SP write wins", rdData, 16'h0040);

    // R9 shared pointer: X wins; Y applies when X holds
    drive(1, 4'd3, 16'h0010, 2'd0, 0, 0, 0, 0, 1, 0, 0, 4'd3);
    drive(0, 0, 0, 2'd0, 0, 2'd3, 2'd1, 0, 2'd3, 2'd2, 0, 4'd3);
    chk("R9 x shared", xAddr, 16'h0010);
    chk("R9 y shared", yAddr, 16'h0010);
    drive(0, 0, 0, 2'd0, 0, 2'd3, 2'd0, 0, 2'd3, 2'd2, 0, 4'd3);
    chk("R9 X update only", rdData, 16'h0011);
    drive(0, 0, 0, 2'd0, 0, 0, 0, 0, 1, 0, 0, 4'd3);
    chk("R9 Y update when X holds", rdData, 16'h0010);

    // R10 unmapped index reads zero
    drive(1, 4'd12, 16'hABCD, 2'd0, 0, 0, 0, 0, 1, 0, 0, 4'd12);
    drive(0, 0, 0, 2'd0, 0, 0, 0, 0, 1, 0, 0, 4'd12);
    chk("R10 unmapped", rdData, 16'h0000);

    done = 1'b1;
    finishRun();
  end
endmodule